// File: doc/BRIEF.md
# UART Receive Timeout and Interrupt Priority Encoder

This block produces the interrupt request and the interrupt identification code for one UART channel. It watches the receive FIFO occupancy against a programmed trigger level. It runs a character-time timeout that flags characters left sitting in a FIFO that is not empty. It keeps a sticky transmit-holding-empty event. It accepts line-status and modem-status conditions as plain inputs from elsewhere in the channel.

A priority encoder masks each source with its enable bit and shows only the most urgent one on `intId`. The line status source ranks first, then the receive source (data or timeout), then transmit empty, then modem status. A lower source appears only once every higher source has cleared. The timeout counter advances on a 16x-oversampling tick. It starts over when the receiver reaches the middle of a stop bit and when software reads the receive holding register.

Top module: `rxto_irq_prio`

## Requirements
- R1: With the FIFO count non-zero, the timeout flag sets on the TMO_TICKS-th `sampleTick` after the last restart (default 4 characters x 10 bits x 16 ticks = 640). It is reported as code 3 when bit 0 of `ierEn` is set.
- R2: A `stopCenter` pulse restarts the timeout count and clears a set timeout flag.
- R3: A `rhrRead` pulse restarts the timeout count but does not clear a timeout flag that is already set.
- R4: While `fifoCount` is 0, the timeout neither counts nor sets. A set flag clears on the edge after the count becomes 0.
- R5: Code 2 (receive data) is shown while `fifoCount` is non-zero and greater than or equal to `trigLevel`. This includes counts above the trigger level. Below the trigger level it is not shown.
- R6: Receive data and receive timeout share one priority level and are both gated by bit 0 of `ierEn`. When both are pending, code 2 is shown.
- R7: After reset the transmit-empty event is pending. Code 4 is shown at once when bit 1 of `ierEn` is set and no higher source is pending.
- R8: `thrWrite` clears the transmit-empty event. An `iirRead` clears it only while code 4 is being shown. An `iirRead` while another code is shown leaves it pending.
- R9: The transmit-empty event sets on the edge after `thrEmpty` rises. It also sets on the edge after bit 1 of `ierEn` rises while `thrEmpty` is high.
- R10: The priority is fixed: line status (code 1, bit 2 of `ierEn`), then receive (codes 2/3), then transmit empty (code 4), then modem status (code 5, bit 3 of `ierEn`). Only one code shows at a time. `irq` is high exactly when the code is non-zero.
- R11: A source whose enable bit is clear is never shown. With `ierEn` = 0, `irq` is low and the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | 16x oversampling tick |
| stopCenter | input | 1 | Pulse at the centre of a received stop bit |
| rhrRead | input | 1 | Receive holding register read strobe |
| fifoCount | input | FIFO_CNT_W | Receive FIFO occupancy |
| trigLevel | input | FIFO_CNT_W | Programmed receive trigger level |
| thrEmpty | input | 1 | Transmit holding register empty (level) |
| thrWrite | input | 1 | Transmit holding register write strobe |
| iirRead | input | 1 | Identification register read strobe |
| ierEn | input | 4 | Enables: [0] receive, [1] transmit empty, [2] line status, [3] modem status |
| lineStatusPend | input | 1 | Line status condition pending |
| modemStatusPend | input | 1 | Modem status condition pending |
| irq | output | 1 | Interrupt request |
| intId | output | 3 | Code: 0 none, 1 line, 2 rx data, 3 rx timeout, 4 tx empty, 5 modem |

## Verification
The embedded assertions check several properties on every cycle. They confirm that the timeout flag drops after an empty FIFO or a stop-bit strobe, and that a clear strobe removes the transmit event. They confirm that an enabled line-status condition always owns the code and that a fully disabled mask never raises `irq`. They also confirm that the flag only rises on a tick. Only the directed scenarios can show the exact 640-tick timeout boundary and the restart by a register read in the middle of a count. The same holds for the selective clearing of the transmit event by an identification read and for the order in which lower sources surface as higher ones are removed.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

  typedef enum logic [2:0] {
    ID_NONE    = 3'd0,
    ID_LINE    = 3'd1,
    ID_RXDATA  = 3'd2,
    ID_RXTMO   = 3'd3,
    ID_TXEMPTY = 3'd4,
    ID_MODEM   = 3'd5
  } intId_e;

  // enable bit positions
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  typedef struct packed {
    logic restartTo;
    logic clearTo;
    logic setTx;
    logic clrTx;
  } ctrlStrobe_t;

endpackage

// File: rtl/rxto_datapath.sv
module rxto_datapath
  import rxto_pkg::*;
#(
  parameter int FIFO_CNT_W = 5,
  parameter int TMO_TICKS  = 640
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleTick,
  input  logic [FIFO_CNT_W-1:0] fifoCount,
  input  logic [FIFO_CNT_W-1:0] trigLevel,
  input  ctrlStrobe_t           stb,
  output logic                  rxDataPend,
  output logic                  toFlag,
  output logic                  txPend
);

  localparam int TMO_W = (TMO_TICKS > 2) ? $clog2(TMO_TICKS) : 1;
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_TICKS - 1);

  logic [TMO_W-1:0] tmoCnt;
  logic             fifoEmpty;
  logic             tmoHit;

  assign fifoEmpty  = (fifoCount == '0);
  assign rxDataPend = !fifoEmpty && (fifoCount >= trigLevel);
  assign tmoHit     = sampleTick && !toFlag && !stb.restartTo && (tmoCnt == TMO_LAST);

  // character-time timeout
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmoCnt <= '0;
      toFlag <= 1'b0;
    end else begin
      if (stb.clearTo || fifoEmpty) begin
        toFlag <= 1'b0;
      end else if (tmoHit) begin
        toFlag <= 1'b1;
      end

      if (stb.restartTo || fifoEmpty || toFlag) begin
        tmoCnt <= '0;
      end else if (sampleTick) begin
        tmoCnt <= (tmoCnt == TMO_LAST) ? '0 : tmoCnt + TMO_W'(1);
      end
    end
  end

  // sticky transmit-empty event, pending out of reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPend <= 1'b1;
    end else if (stb.clrTx) begin
      txPend <= 1'b0;
    end else if (stb.setTx) begin
      txPend <= 1'b1;
    end
  end

  // R4
  to_empty_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0) |=> !toFlag);

  // R2
  to_stop_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearTo |=> !toFlag);

  // R1
  to_tick_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> $past(sampleTick));

  // R8
  tx_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrTx |=> !txPend);

endmodule

// File: rtl/rxto_control.sv
module rxto_control
  import rxto_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stopCenter,
  input  logic        rhrRead,
  input  logic        thrEmpty,
  input  logic        thrWrite,
  input  logic        iirRead,
  input  logic [3:0]  ierEn,
  input  logic        lineStatusPend,
  input  logic        modemStatusPend,
  input  logic        rxDataPend,
  input  logic        toFlag,
  input  logic        txPend,
  output ctrlStrobe_t stb,
  output logic        irq,
  output logic [2:0]  intId
);

  logic   thrEmptyQ;
  logic   txEnQ;
  logic   lsAct, rxAct, txAct, msAct;
  intId_e curId;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrEmptyQ <= 1'b1;
      txEnQ     <= 1'b0;
    end else begin
      thrEmptyQ <= thrEmpty;
      txEnQ     <= ierEn[EN_TX];
    end
  end

  assign lsAct = lineStatusPend  && ierEn[EN_LS];
  assign rxAct = (rxDataPend || toFlag) && ierEn[EN_RX];
  assign txAct = txPend          && ierEn[EN_TX];
  assign msAct = modemStatusPend && ierEn[EN_MS];

  always_comb begin
    if (lsAct)             curId = ID_LINE;
    else if (rxAct)        curId = rxDataPend ? ID_RXDATA : ID_RXTMO;
    else if (txAct)        curId = ID_TXEMPTY;
    else if (msAct)        curId = ID_MODEM;
    else                   curId = ID_NONE;
  end

  always_comb begin
    stb.restartTo = stopCenter || rhrRead;
    stb.clearTo   = stopCenter;
    stb.setTx     = thrEmpty && (!thrEmptyQ || (ierEn[EN_TX] && !txEnQ));
    stb.clrTx     = thrWrite || (iirRead && (curId == ID_TXEMPTY));
  end

  assign intId = curId;
  assign irq   = (curId != ID_NONE);

  // R10
  line_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStatusPend && ierEn[EN_LS]) |-> (intId == ID_LINE));

  // R11
  mask_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ierEn == 4'b0000) |-> !irq);

  // R6
  rx_share_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDataPend && ierEn[EN_RX] && !lsAct) |-> (intId == ID_RXDATA));

endmodule

// File: rtl/rxto_irq_prio.sv
module rxto_irq_prio
  import rxto_pkg::*;
#(
  parameter int FIFO_CNT_W    = 5,
  parameter int TICKS_PER_BIT = 16,
  parameter int BITS_PER_CHAR = 10,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleTick,
  input  logic                  stopCenter,
  input  logic                  rhrRead,
  input  logic [FIFO_CNT_W-1:0] fifoCount,
  input  logic [FIFO_CNT_W-1:0] trigLevel,
  input  logic                  thrEmpty,
  input  logic                  thrWrite,
  input  logic                  iirRead,
  input  logic [3:0]            ierEn,
  input  logic                  lineStatusPend,
  input  logic                  modemStatusPend,
  output logic                  irq,
  output logic [2:0]            intId
);

  localparam int TMO_TICKS = TICKS_PER_BIT * BITS_PER_CHAR * TIMEOUT_CHARS;

  ctrlStrobe_t stb;
  logic        rxDataPend;
  logic        toFlag;
  logic        txPend;

  rxto_datapath #(
    .FIFO_CNT_W (FIFO_CNT_W),
    .TMO_TICKS  (TMO_TICKS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .fifoCount  (fifoCount),
    .trigLevel  (trigLevel),
    .stb        (stb),
    .rxDataPend (rxDataPend),
    .toFlag     (toFlag),
    .txPend     (txPend)
  );

  rxto_control u_ctl (
    .clk             (clk),
    .rstN            (rstN),
    .stopCenter      (stopCenter),
    .rhrRead         (rhrRead),
    .thrEmpty        (thrEmpty),
    .thrWrite        (thrWrite),
    .iirRead         (iirRead),
    .ierEn           (ierEn),
    .lineStatusPend  (lineStatusPend),
    .modemStatusPend (modemStatusPend),
    .rxDataPend      (rxDataPend),
    .toFlag          (toFlag),
    .txPend          (txPend),
    .stb             (stb),
    .irq             (irq),
    .intId           (intId)
  );

endmodule

// File: tb/rxto_irq_prio_tb.sv
`timescale 1ns/1ps
module rxto_irq_prio_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       stopCenter = 1'b0;
  logic       rhrRead = 1'b0;
  logic [4:0] fifoCount = '0;
  logic [4:0] trigLevel = 5'd8;
  logic       thrEmpty = 1'b1;
  logic       thrWrite = 1'b0;
  logic       iirRead = 1'b0;
  logic [3:0] ierEn = 4'b0010;
  logic       lineStatusPend = 1'b0;
  logic       modemStatusPend = 1'b0;
  logic       irq;
  logic [2:0] intId;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  localparam int TMO = 640;

  always #2.5 clk = ~clk;

  rxto_irq_prio u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .stopCenter(stopCenter),
    .rhrRead(rhrRead), .fifoCount(fifoCount), .trigLevel(trigLevel),
    .thrEmpty(thrEmpty), .thrWrite(thrWrite), .iirRead(iirRead), .ierEn(ierEn),
    .lineStatusPend(lineStatusPend), .modemStatusPend(modemStatusPend),
    .irq(irq), .intId(intId)
  );

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expectId(string req, logic [2:0] eId);
    nChecks++;
    if (intId !== eId || irq !== (eId != 3'd0)) begin
      nFail++;
      $display("FAIL %s: id=%0d irq=%0b expected id=%0d irq=%0b",
               req, intId, irq, eId, (eId != 3'd0));
    end
  endtask

  task automatic pulseStop();
    stopCenter = 1'b1; cyc(); stopCenter = 1'b0;
  endtask

  // R7 R8
  task automatic testTxReset();
    expectId("R7 tx pending after reset", 3'd4);
    iirRead = 1'b1; cyc(); iirRead = 1'b0;
    expectId("R8 iir read clears tx", 3'd0);
  endtask

  // R9 R8
  task automatic testTxSet();
    thrEmpty = 1'b0; thrWrite = 1'b1; cyc(); thrWrite = 1'b0;
    expectId("R8 thr write keeps none", 3'd0);
    thrEmpty = 1'b1; cyc();
    expectId("R9 rise of thrEmpty", 3'd4);
    thrWrite = 1'b1; cyc(); thrWrite = 1'b0;
    expectId("R8 thr write clears tx", 3'd0);
    ierEn = 4'b0000; cyc();
    ierEn = 4'b0010; cyc();
    expectId("R9 enable rise while empty", 3'd4);
    iirRead = 1'b1; cyc(); iirRead = 1'b0;
  endtask

  // R1 R2 R3 R4
  task automatic testTimeout();
    ierEn = 4'b0001; trigLevel = 5'd8; fifoCount = 5'd3;
    pulseStop();
    sampleTick = 1'b1;
    cyc(TMO - 1);
    expectId("R1 no timeout one tick early", 3'd0);
    cyc();
    expectId("R1 timeout at 640 ticks", 3'd3);
    sampleTick = 1'b0;
    pulseStop();
    expectId("R2 stop centre clears timeout", 3'd0);
    sampleTick = 1'b1;
    cyc(600);
    rhrRead = 1'b1; cyc(); rhrRead = 1'b0;
    cyc(TMO - 1);
    expectId("R3 read restarted count", 3'd0);
    cyc();
    expectId("R3 timeout after read restart", 3'd3);
    sampleTick = 1'b0;
    rhrRead = 1'b1; cyc(); rhrRead = 1'b0;
    expectId("R3 read keeps set flag", 3'd3);
    fifoCount = 5'd0; cyc();
    expectId("R4 empty clears flag", 3'd0);
    sampleTick = 1'b1;
    cyc(TMO + 60);
    expectId("R4 no timeout while empty", 3'd0);
    fifoCount = 5'd3;
    cyc(TMO - 1);
    expectId("R4 count held at zero while empty", 3'd0);
    cyc();
    expectId("R1 timeout after refill", 3'd3);
    sampleTick = 1'b0;
  endtask

  // R5 R6
  task automatic testRxData();
    fifoCount = 5'd8; cyc();
    expectId("R6 data shown over timeout", 3'd2);
    fifoCount = 5'd12; cyc();
    expectId("R5 above trigger", 3'd2);
    ierEn = 4'b0000; cyc();
    expectId("R6 bit0 gates rx", 3'd0);
    ierEn = 4'b0001;
    fifoCount = 5'd0; cyc();
    fifoCount = 5'd7; cyc();
    expectId("R5 below trigger", 3'd0);
  endtask

  // R10 R8
  task automatic testPriority();
    thrEmpty = 1'b0; cyc(); thrEmpty = 1'b1; cyc();
    ierEn = 4'hF; lineStatusPend = 1'b1; modemStatusPend = 1'b1;
    fifoCount = 5'd8; cyc();
    expectId("R10 line first", 3'd1);
    iirRead = 1'b1; cyc(); iirRead = 1'b0;
    lineStatusPend = 1'b0; cyc();
    expectId("R10 rx second", 3'd2);
    fifoCount = 5'd0; cyc();
    expectId("R8 tx survives read under line", 3'd4);
    thrWrite = 1'b1; cyc(); thrWrite = 1'b0;
    expectId("R10 modem last", 3'd5);
    modemStatusPend = 1'b0; cyc();
    expectId("R10 none left", 3'd0);
  endtask

  // R11
  task automatic testMask();
    lineStatusPend = 1'b1; modemStatusPend = 1'b1; fifoCount = 5'd9;
    thrEmpty = 1'b0; cyc(); thrEmpty = 1'b1;
    ierEn = 4'b0000; cyc();
    expectId("R11 all masked", 3'd0);
    ierEn = 4'b1000; cyc();
    expectId("R11 only modem enabled", 3'd5);
    ierEn = 4'b0000; lineStatusPend = 1'b0; modemStatusPend = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc();
    testTxReset();
    testTxSet();
    testTimeout();
    testRxData();
    testPriority();
    testMask();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule